// File: doc/BRIEF.md
# Framed Ones-Count Detector

This block watches a serial bit stream, one bit per clock, and cuts it into non-overlapping frames. While idle it waits for a 1; that bit opens a frame, and the following bits up to the frame length are taken into the same frame whatever their values. No other frame can start during that time. When the frame closes, the block raises its output for exactly one clock period if the frame held an even number of 1s. With the default length of four and a leading 1, an even count means two or four 1s.

The output is decoded from state registers alone, so it changes only at clock edges. It is high during the period that follows the edge on which the last frame bit was sampled. That period also counts as idle, so a 1 sampled then opens the next frame at once. An active-high synchronous reset returns the block to idle.

Top module: `fpd_frame_detector`

## Requirements
- R1: A synchronous reset, which takes priority over `x_in`, returns the block to idle and drives `z_out` to 0 from the next clock period on.
- R2: A 0 sampled while idle leaves the block idle with `z_out` at 0.
- R3: A 1 sampled while idle opens a frame; the next three sampled bits belong to that frame whatever their values, and a 1 among them does not open a new frame.
- R4: At the close of a frame `z_out` is 1 when the frame's four bits hold two or four 1s (counting the opening 1), and 0 when they hold one or three.
- R5: `z_out` rises in the clock period following the edge that samples the fourth frame bit and stays high for exactly one period.
- R6: In the period where `z_out` is 1, a sampled 1 opens a new frame at once and a sampled 0 returns the block to idle with `z_out` 0.
- R7: A frame that closes with an odd count returns directly to idle, and the very next sampled 1 opens a new frame.
- R8: For the input stream 0 1 0 1 0 1 1 1 1 1 1 1 0 1 0 0 1 0 0 0 1 1 0 0, the per-period output is 0 0 0 0 1 0 0 0 1 0 0 0 0 0 0 0 1 0 0 0 0 0 0 1.
- R9: `z_out` depends on state only: a change of `x_in` between clock edges does not change `z_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; `x_in` is sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| x_in | input | 1 | Serial data bit |
| z_out | output | 1 | One-period flag for a frame with an even count of 1s |

## Verification
The hardest situation to reach is a frame that opens in the very period where `z_out` is high, or right after a frame that closed with an odd count. Both leave no idle period between frames, so an error in frame alignment shows only several bits later. The stimulus builds these back-to-back cases on purpose with chained frames, replays the example stream, and then runs a long random stream. A reference model that counts 1s per frame checks every period. The bench also toggles `x_in` in mid-period while the flag is high to show that the output does not follow the input.

// File: rtl/fpd_pkg.sv
package fpd_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_FRAME = 2'd1,
        PH_HIT   = 2'd2
    } phase_e;

    typedef struct packed {
        logic start;
        logic take;
    } step_t;

    function automatic logic parity_next(input logic acc, input logic bit_in);
        return acc ^ bit_in;
    endfunction

    function automatic logic can_open(input phase_e ph);
        return ph != PH_FRAME;
    endfunction

endpackage

// File: rtl/fpd_pos_counter.sv
module fpd_pos_counter #(
    parameter int FRAME_BITS = 4,
    parameter int POS_W      = $clog2(FRAME_BITS)
) (
    input  logic                clk,
    input  logic                rst,
    input  fpd_pkg::step_t      step,
    output logic [POS_W-1:0]    idx,
    output logic                last
);
    localparam logic [POS_W-1:0] LAST_IDX = POS_W'(FRAME_BITS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
        end else if (step.start) begin
            idx <= POS_W'(1);
        end else if (step.take) begin
            idx <= last ? '0 : idx + 1'b1;
        end
    end

    assign last = (idx == LAST_IDX);
endmodule

// File: rtl/fpd_parity_acc.sv
module fpd_parity_acc (
    input  logic           clk,
    input  logic           rst,
    input  fpd_pkg::step_t step,
    input  logic           x_in,
    output logic           odd,
    output logic           close_even
);
    import fpd_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) begin
            odd <= 1'b0;
        end else if (step.start) begin
            odd <= 1'b1;
        end else if (step.take) begin
            odd <= parity_next(odd, x_in);
        end
    end

    assign close_even = ~parity_next(odd, x_in);
endmodule

// File: rtl/fpd_frame_detector.sv
module fpd_frame_detector #(
    parameter int FRAME_BITS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic x_in,
    output logic z_out
);
    import fpd_pkg::*;

    localparam int POS_W = $clog2(FRAME_BITS);

    phase_e             phase_q;
    phase_e             phase_d;
    step_t              step;
    logic [POS_W-1:0]   bit_idx;
    logic               last_bit;
    logic               odd_q;
    logic               close_even;
    logic               in_frame;

    assign in_frame = (phase_q == PH_FRAME);

    always_comb begin
        step.start = can_open(phase_q) && x_in;
        step.take  = in_frame;
    end

    fpd_pos_counter #(
        .FRAME_BITS (FRAME_BITS),
        .POS_W      (POS_W)
    ) u_pos (
        .clk  (clk),
        .rst  (rst),
        .step (step),
        .idx  (bit_idx),
        .last (last_bit)
    );

    fpd_parity_acc u_par (
        .clk        (clk),
        .rst        (rst),
        .step       (step),
        .x_in       (x_in),
        .odd        (odd_q),
        .close_even (close_even)
    );

    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_FRAME: begin
                if (last_bit) begin
                    phase_d = close_even ? PH_HIT : PH_IDLE;
                end
            end
            default: begin
                phase_d = x_in ? PH_FRAME : PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
        end else begin
            phase_q <= phase_d;
        end
    end

    assign z_out = (phase_q == PH_HIT);
endmodule

// File: rtl/fpd_checker.sv
module fpd_checker #(
    parameter int FRAME_BITS = 4,
    parameter int POS_W      = $clog2(FRAME_BITS)
) (
    input logic             clk,
    input logic             rst,
    input logic             x_in,
    input logic             z_out,
    input logic             in_frame,
    input logic [POS_W-1:0] bit_idx
);
    localparam int CW = $clog2(FRAME_BITS + 1);
    localparam logic [POS_W-1:0] LAST_IDX = POS_W'(FRAME_BITS - 1);

    logic [CW-1:0] ones_q;
    logic          closing;
    logic          count_even;

    always_ff @(posedge clk) begin
        if (rst) begin
            ones_q <= '0;
        end else if (!in_frame && x_in) begin
            ones_q <= CW'(1);
        end else if (in_frame) begin
            ones_q <= ones_q + CW'(x_in);
        end
    end

    assign closing    = in_frame && (bit_idx == LAST_IDX);
    assign count_even = ~(ones_q[0] ^ x_in);

    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!z_out && !in_frame));

    // R2
    a_r2_idle_zero_stays: assert property (@(posedge clk) disable iff (rst)
        (!in_frame && !x_in) |=> (!in_frame && !z_out));

    // R3
    a_r3_one_opens: assert property (@(posedge clk) disable iff (rst)
        (!in_frame && x_in) |=> (in_frame && bit_idx == POS_W'(1)));

    // R3
    a_r3_frame_held: assert property (@(posedge clk) disable iff (rst)
        (in_frame && bit_idx != LAST_IDX) |=> (in_frame && !z_out));

    // R4
    a_r4_even_flags: assert property (@(posedge clk) disable iff (rst)
        (closing && count_even) |=> z_out);

    // R4
    a_r4_odd_silent: assert property (@(posedge clk) disable iff (rst)
        (closing && !count_even) |=> (!z_out && !in_frame));

    // R5
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
        z_out |=> !z_out);

    // R6
    a_r6_open_on_flag: assert property (@(posedge clk) disable iff (rst)
        (z_out && x_in) |=> in_frame);
endmodule

bind fpd_frame_detector fpd_checker #(
    .FRAME_BITS (FRAME_BITS),
    .POS_W      (POS_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .x_in     (x_in),
    .z_out    (z_out),
    .in_frame (in_frame),
    .bit_idx  (bit_idx)
);

// File: tb/test_fpd_frame_detector.sv
module test_fpd_frame_detector;
    localparam int CLK_PERIOD = 10;

    logic clk  = 1'b0;
    logic rst  = 1'b1;
    logic x_in = 1'b0;
    logic z_out;

    int n_tests = 0;
    int n_fail  = 0;

    bit    exp_q[$];
    string tag_q[$];

    bit m_busy = 1'b0;
    int m_pos  = 0;
    int m_ones = 0;

    fpd_frame_detector i_fpd_frame_detector (
        .clk   (clk),
        .rst   (rst),
        .x_in  (x_in),
        .z_out (z_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic drive(input bit b, input bit r, input string tag,
                         input bit use_given = 1'b0, input bit given = 1'b0);
        bit ez;
        @(negedge clk);
        x_in = b;
        rst  = r;
        if (r) begin
            m_busy = 1'b0; m_pos = 0; m_ones = 0; ez = 1'b0;
        end else if (!m_busy) begin
            if (b) begin
                m_busy = 1'b1; m_pos = 1; m_ones = 1;
            end
            ez = 1'b0;
        end else begin
            m_ones += int'(b);
            m_pos++;
            if (m_pos == 4) begin
                m_busy = 1'b0;
                ez = (m_ones == 2) || (m_ones == 4);
            end else begin
                ez = 1'b0;
            end
        end
        exp_q.push_back(use_given ? given : ez);
        tag_q.push_back(tag);
    endtask

    task automatic frame4(input bit [3:0] bits, input string tag);
        for (int i = 3; i >= 0; i--) drive(bits[i], 1'b0, tag);
    endtask

    // R9: toggle x_in mid-period and look for any change of z_out
    task automatic glitch_check(input string tag);
        bit snap;
        @(posedge clk);
        #2;
        snap = z_out;
        x_in = ~x_in;
        #1;
        n_tests++;
        if (z_out !== snap) begin
            n_fail++;
            $display("FAIL %s: z_out=%0b expected %0b", tag, z_out, snap);
        end
        x_in = ~x_in;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                bit    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_tests++;
                if (z_out !== e) begin
                    n_fail++;
                    $display("FAIL %s: z_out=%0b expected %0b", t, z_out, e);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not end, got hang expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        bit ex_in  [24] = '{0,1,0,1,0,1,1,1,1,1,1,1,0,1,0,0,1,0,0,0,1,1,0,0};
        bit ex_out [24] = '{0,0,0,0,1,0,0,0,1,0,0,0,0,0,0,0,1,0,0,0,0,0,0,1};

        drive(1'b1, 1'b1, "R1 reset with x high");
        drive(1'b0, 1'b1, "R1 reset");
        repeat (3) drive(1'b0, 1'b0, "R2 idle zeros");

        // R3: ones inside a frame do not restart it (1 0 1 1 -> three ones)
        frame4(4'b1011, "R3 frame with inner ones");
        drive(1'b0, 1'b0, "R3 after odd frame");

        // R4 targeted counts
        frame4(4'b1100, "R4 two ones");
        drive(1'b0, 1'b0, "R5 pulse ends");
        frame4(4'b1111, "R4 four ones");
        drive(1'b0, 1'b0, "R6 zero on flag");
        frame4(4'b1000, "R4 one one");
        frame4(4'b1110, "R4 three ones");
        drive(1'b0, 1'b0, "R4 idle after odd");

        // R6: new frame opened in the flag period
        frame4(4'b1001, "R6 first frame");
        glitch_check("R9 flag steady under x toggle");
        frame4(4'b1010, "R6 frame opened on flag");
        frame4(4'b1010, "R6 chained again");

        // R7: odd close then immediate new frame
        frame4(4'b1101, "R7 odd frame");
        frame4(4'b1001, "R7 frame right after odd close");
        drive(1'b0, 1'b0, "R7 tail");

        // R1: reset in the middle of a frame
        drive(1'b1, 1'b0, "R1 open frame");
        drive(1'b1, 1'b0, "R1 frame bit");
        drive(1'b1, 1'b1, "R1 reset mid frame");
        repeat (3) drive(1'b0, 1'b0, "R1 idle after reset");
        frame4(4'b1100, "R1 clean frame after reset");
        drive(1'b0, 1'b0, "R1 tail");

        // R8: stated example stream from idle
        for (int i = 0; i < 24; i++) drive(ex_in[i], 1'b0, "R8 example", 1'b1, ex_out[i]);
        drive(1'b0, 1'b0, "R8 tail");

        // R4 random stream with rare resets (R1)
        for (int i = 0; i < 5000; i++) begin
            bit r;
            r = ($urandom_range(0, 99) == 0);
            drive(1'b1 & $urandom_range(0, 1), r, r ? "R1 random reset" : "R4 random");
        end

        wait (exp_q.size() == 0);
        @(posedge clk);
        #2;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule